// File: doc/BRIEF.md
# I2C Phase-Counted Bit Timing Generator

This block turns single bus-level commands into the SCL and SDA waveforms of an I2C master. It runs from one system clock. Every SCL bit period is divided into eight low sub-phases and eight high sub-phases, and each sub-phase lasts a programmable number of clocks. The point where SDA changes, the START setup and hold, and the STOP setup are all placed as whole multiples of those sub-phases, plus or minus one clock. A byte-level controller above it issues one command at a time (START from an idle bus, repeated START, write bit, read bit, STOP) through a valid/ready handshake. It receives a one-cycle done pulse when the waveform is complete and, for a read bit, the sampled SDA value.

The lines are open-drain. The block only ever asserts an output enable that pulls a line low. When the enable is deasserted, the line is released to the pull-up. Timing is set by a 48-bit configuration word that is captured with each accepted command. The low and high divisors sit in the lower 32 bits. The data-update, START-setup and STOP-setup counts sit in the upper 16 bits.

Top module: `i2c_phase_timer`

## Requirements
- R1: After reset and while idle, `scl_oe` = 0 and `sda_oe` = 0 (both lines released), `cmd_ready` = 1 and `done` = 0. While idle with no command accepted, neither line enable changes.
- R2: Config layout: `cfg_word[15:0]` = divl and `cfg_word[31:16]` = divh, with l = divl+1 and h = divh+1. A low sub-phase lasts l clocks and a high sub-phase lasts h clocks. For a write or read bit accepted at clock edge A, with SCL held low on entry, `scl_oe` drops at edge A+8l and rises again at edge A+8l+8h.
- R3: The data-update count is `cfg_word[43:40]`, and s = count+1, clamped to 7. In write, read and STOP commands, SDA takes its new level at edge A+l*s+1. For a write bit, `sda_oe` = NOT `cmd_wbit`. A read bit releases SDA. STOP pulls SDA low.
- R4: START (`cmd_op` = 0) begins with both lines released. With u = `cfg_word[45:44]`+1, `sda_oe` rises at edge A+8h*u+1 and `scl_oe` rises at edge A+8h*(2u+1). The SDA hold before SCL falls is therefore 8h*(u+1)-1 clocks.
- R5: Repeated START (`cmd_op` = 1) releases SDA at A+l*s+1 and releases SCL at A+8l. It then pulls SDA low 8h*u+1 clocks after the SCL release, and pulls SCL low 8h*(2u+1) clocks after the SCL release.
- R6: STOP (`cmd_op` = 4) pulls SDA low at A+l*s+1 and releases SCL at A+8l. With p = `cfg_word[47:46]`+1, it releases SDA at A+8l+8h*p+1.
- R7: A read bit (`cmd_op` = 3) captures `sda_in` as present in the cycle that ends at edge A+8l+4h+1, which is just after high sub-phase 4 of 8. `rd_bit` holds that value when `done` is asserted. A write bit is `cmd_op` = 2.
- R8: `cmd_ready` drops at the edge that accepts a defined opcode and stays low until the command ends. `done` is a one-cycle pulse in the first cycle after the edge that completes the waveform, and `cmd_ready` is high in that cycle. That edge is the final SCL fall for START, repeated START and bits, and the SDA release for STOP.
- R9: The config word is sampled only at the accepting edge. Changes to `cfg_word` while a command is running do not alter its timing.
- R10: Undefined opcodes (5 to 7) are accepted, leave both line enables unchanged, and produce `done` in the cycle after acceptance without dropping `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High while idle; a command is taken when valid and ready |
| cmd_op | input | 3 | 0 START, 1 repeated START, 2 write bit, 3 read bit, 4 STOP |
| cmd_wbit | input | 1 | Data value for a write bit |
| cfg_word | input | 48 | Divisors and setup/update counts, captured on accept |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | SDA value sampled by the last read bit |

## Verification
The bound checker watches, on every cycle, the handshake and completion relations. These are: ready falling after an accept, ready rising only together with done, undefined opcodes completing at once with the lines untouched, and the line enables and the read result staying frozen while idle. The exact clock placement of each SCL and SDA edge relative to the accepting edge, the clamp on the data-update count, the sample point of a read, and the indifference to config changes during a command can only be shown by the bench. It runs directed command sequences under four configurations, including the standard-mode and fast-mode divisor settings.

// File: rtl/i2c_phase_pkg.sv
package i2c_phase_pkg;

    localparam int DIV_W   = 16;              // divisor field width
    localparam int CTL_W   = 16;              // control field width
    localparam int CFG_W   = 2 * DIV_W + CTL_W;
    localparam int PH_W    = 7;               // holds up to 16*4+15 phases
    localparam int S_MAX   = 7;               // clamp on update sub-phase

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } op_e;

    typedef struct packed {
        logic [DIV_W-1:0] divl;
        logic [DIV_W-1:0] divh;
        logic [3:0]       s;    // update sub-phase, 1..7
        logic [2:0]       u;    // START setup multiple, 1..4
        logic [2:0]       p;    // STOP setup multiple, 1..4
    } timing_t;

endpackage

// File: rtl/ipt_cfg_unpack.sv
module ipt_cfg_unpack
    import i2c_phase_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    output timing_t          tm
);
    logic [CTL_W-1:0] ctl;
    logic [4:0]       s_raw;

    always_comb begin
        ctl     = cfg[CFG_W-1 -: CTL_W];
        s_raw   = {1'b0, ctl[11:8]} + 5'd1;
        tm.divl = cfg[DIV_W-1:0];
        tm.divh = cfg[2*DIV_W-1:DIV_W];
        tm.s    = (s_raw > 5'(S_MAX)) ? 4'(S_MAX) : s_raw[3:0];
        tm.u    = {1'b0, ctl[13:12]} + 3'd1;
        tm.p    = {1'b0, ctl[15:14]} + 3'd1;
    end
endmodule

// File: rtl/ipt_phase_cnt.sv
module ipt_phase_cnt #(
    parameter int DIV_W = 16,
    parameter int PH_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PH_W-1:0]  load_phase,
    input  logic             run,
    input  logic [DIV_W-1:0] divl,
    input  logic [DIV_W-1:0] divh,
    output logic [PH_W-1:0]  phase,
    output logic             first_clk,
    output logic             tick
);
    localparam logic [PH_W-1:0] LOW_PHASES = PH_W'(8);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [PH_W-1:0]  ph;
    } cnt_t;

    cnt_t             r_q, r_d;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (r_q.ph < LOW_PHASES) ? divl : divh;
        tick  = run && (r_q.cnt == limit);
        r_d   = r_q;
        if (load) begin
            r_d.cnt = '0;
            r_d.ph  = load_phase;
        end else if (tick) begin
            r_d.cnt = '0;
            r_d.ph  = r_q.ph + PH_W'(1);
        end else if (run) begin
            r_d.cnt = r_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign phase     = r_q.ph;
    assign first_clk = (r_q.cnt == '0);
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
    import i2c_phase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_wbit,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             done,
    output logic             rd_bit
);
    localparam logic [PH_W-1:0] PH_LOW_LAST  = PH_W'(7);
    localparam logic [PH_W-1:0] PH_HIGH_MID  = PH_W'(12);
    localparam logic [PH_W-1:0] PH_BIT_LAST  = PH_W'(15);
    localparam logic [PH_W-1:0] PH_HIGH_BASE = PH_W'(8);

    typedef struct packed {
        logic             busy;
        op_e              op;
        logic             wbit;
        logic [CFG_W-1:0] cfg;
        logic             scl_low;
        logic             sda_low;
        logic             done;
        logic             rd;
    } state_t;

    state_t          r_q, r_d;
    timing_t         tm;
    logic [PH_W-1:0] phase;
    logic            first_clk, tick;
    logic            load;
    logic [PH_W-1:0] load_ph;
    logic [PH_W-1:0] t_upd, t_sta_sda, t_sta_end, t_sto_sda;
    logic            at_upd, scl_up, sta_sda, sta_end, sto_sda, rd_pt, bit_end;

    ipt_cfg_unpack u_unpack (
        .cfg (r_q.cfg),
        .tm  (tm)
    );

    ipt_phase_cnt #(.DIV_W(DIV_W), .PH_W(PH_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_phase (load_ph),
        .run        (r_q.busy),
        .divl       (tm.divl),
        .divh       (tm.divh),
        .phase      (phase),
        .first_clk  (first_clk),
        .tick       (tick)
    );

    // phase targets derived from the captured configuration
    always_comb begin
        t_upd     = PH_W'(tm.s);
        t_sta_sda = PH_HIGH_BASE + PH_W'({tm.u, 3'b000});
        t_sta_end = PH_W'({tm.u, 4'b0000}) + PH_BIT_LAST;
        t_sto_sda = PH_HIGH_BASE + PH_W'({tm.p, 3'b000});
        at_upd    = first_clk && (phase == t_upd);
        scl_up    = tick && (phase == PH_LOW_LAST);
        sta_sda   = first_clk && (phase == t_sta_sda);
        sta_end   = tick && (phase == t_sta_end);
        sto_sda   = first_clk && (phase == t_sto_sda);
        rd_pt     = first_clk && (phase == PH_HIGH_MID);
        bit_end   = tick && (phase == PH_BIT_LAST);
    end

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        load    = 1'b0;
        load_ph = '0;
        if (!r_q.busy) begin
            if (cmd_valid) begin
                if (cmd_op <= 3'd4) begin
                    r_d.busy = 1'b1;
                    r_d.op   = op_e'(cmd_op);
                    r_d.wbit = cmd_wbit;
                    r_d.cfg  = cfg_word;
                    load     = 1'b1;
                    load_ph  = (op_e'(cmd_op) == OP_START) ? PH_HIGH_BASE : '0;
                end else begin
                    r_d.done = 1'b1;
                end
            end
        end else begin
            unique case (r_q.op)
                OP_START, OP_RESTART: begin
                    if (r_q.op == OP_RESTART && at_upd) r_d.sda_low = 1'b0;
                    if (scl_up)  r_d.scl_low = 1'b0;
                    if (sta_sda) r_d.sda_low = 1'b1;
                    if (sta_end) begin
                        r_d.scl_low = 1'b1;
                        r_d.busy    = 1'b0;
                        r_d.done    = 1'b1;
                    end
                end
                OP_WRITE, OP_READ: begin
                    if (at_upd)
                        r_d.sda_low = (r_q.op == OP_WRITE) ? !r_q.wbit : 1'b0;
                    if (scl_up) r_d.scl_low = 1'b0;
                    if (rd_pt && r_q.op == OP_READ) r_d.rd = sda_in;
                    if (bit_end) begin
                        r_d.scl_low = 1'b1;
                        r_d.busy    = 1'b0;
                        r_d.done    = 1'b1;
                    end
                end
                OP_STOP: begin
                    if (at_upd) r_d.sda_low = 1'b1;
                    if (scl_up) r_d.scl_low = 1'b0;
                    if (sto_sda) begin
                        r_d.sda_low = 1'b0;
                        r_d.busy    = 1'b0;
                        r_d.done    = 1'b1;
                    end
                end
                default: r_d.busy = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.op   <= OP_START;
        end else begin
            r_q      <= r_d;
        end
    end

    assign cmd_ready = !r_q.busy;
    assign scl_oe    = r_q.scl_low;
    assign sda_oe    = r_q.sda_low;
    assign done      = r_q.done;
    assign rd_bit    = r_q.rd;
endmodule

// File: rtl/i2c_phase_timer_chk.sv
module i2c_phase_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [2:0] cmd_op,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       done,
    input logic       rd_bit
);
    // R1
    idle_lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid) |=> ($stable(scl_oe) && $stable(sda_oe)));

    // R8
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op <= 3'd4) |=> !cmd_ready);

    // R8
    ready_rise_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> done);

    // R10
    undef_op_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op > 3'd4)
            |=> (done && cmd_ready && $stable(scl_oe) && $stable(sda_oe)));

    // R7
    rd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_bit) |-> $past(!cmd_ready));

    // R2
    scl_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> $past(!cmd_ready));
endmodule

bind i2c_phase_timer i2c_phase_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .done      (done),
    .rd_bit    (rd_bit)
);

// File: tb/sim_i2c_phase_timer.sv
module sim_i2c_phase_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic        cmd_wbit = 1'b0;
    logic [47:0] cfg_word = '0;
    logic        sda_in = 1'b1;
    logic        scl_oe, sda_oe, done, rd_bit;

    int n_chk = 0;
    int n_bad = 0;
    int t_scl1, t_scl2, t_sda1, t_sda2, t_done;
    logic rd_got, rdy_k0;

    always #5 clk = ~clk;

    i2c_phase_timer u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_wbit(cmd_wbit), .cfg_word(cfg_word), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .rd_bit(rd_bit)
    );

    function automatic logic [47:0] mk_cfg(input int dl, input int dh, input int upd,
                                           input int sta, input int sto);
        logic [15:0] ctl;
        ctl = {sto[1:0], sta[1:0], upd[3:0], 8'h00};
        return {ctl, dh[15:0], dl[15:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue one command at a negedge and trace edges relative to the accept edge.
    task automatic run_cmd(input logic [2:0] op, input logic wb, input logic [47:0] cfg,
                           input int chg_k, input logic v0, input logic v1);
        logic ps, pd;
        ps = scl_oe; pd = sda_oe;
        t_scl1 = -1; t_scl2 = -1; t_sda1 = -1; t_sda2 = -1; t_done = -1;
        cmd_op = op; cmd_wbit = wb; cfg_word = cfg; cmd_valid = 1'b1; sda_in = v0;
        @(posedge clk);
        for (int k = 0; k < 4000 && t_done < 0; k++) begin
            @(negedge clk);
            if (k == 0) begin
                cmd_valid = 1'b0;
                cfg_word  = ~cfg;     // must be ignored until next accept
                rdy_k0    = cmd_ready;
            end
            if (scl_oe != ps) begin
                if (t_scl1 < 0) t_scl1 = k; else if (t_scl2 < 0) t_scl2 = k;
                ps = scl_oe;
            end
            if (sda_oe != pd) begin
                if (t_sda1 < 0) t_sda1 = k; else if (t_sda2 < 0) t_sda2 = k;
                pd = sda_oe;
            end
            if (done) begin
                t_done = k;
                rd_got = rd_bit;
            end
            sda_in = (k >= chg_k) ? v1 : v0;
        end
        if (t_done < 0) chk("watchdog", 0, 1);
    endtask

    task automatic t_reset();
        chk("R1 scl_oe reset", int'(scl_oe), 0);
        chk("R1 sda_oe reset", int'(sda_oe), 0);
        chk("R1 ready reset", int'(cmd_ready), 1);
        chk("R1 done reset", int'(done), 0);
    endtask

    task automatic t_small_cfg();
        logic [47:0] c;
        c = mk_cfg(3, 2, 1, 0, 0);   // l=4 h=3 s=2 u=1 p=1
        run_cmd(3'd0, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R4 start sda fall", t_sda1, 25);
        chk("R4 start scl fall", t_scl1, 72);
        chk("R8 start done", t_done, 72);
        chk("R8 ready low after accept", int'(rdy_k0), 0);
        run_cmd(3'd2, 1'b1, c, 9999, 1'b1, 1'b1);
        chk("R3 write1 sda release", t_sda1, 9);
        chk("R2 bit scl rise", t_scl1, 32);
        chk("R2 bit scl fall", t_scl2, 56);
        chk("R9 done timing with cfg changed", t_done, 56);
        run_cmd(3'd2, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R3 write0 sda low", t_sda1, 9);
        chk("R3 write0 level", int'(sda_oe), 1);
        run_cmd(3'd3, 1'b0, c, 44, 1'b0, 1'b1);
        chk("R3 read releases sda", t_sda1, 9);
        chk("R7 sample after late-side change", int'(rd_got), 1);
        run_cmd(3'd3, 1'b0, c, 45, 1'b0, 1'b1);
        chk("R7 change after sample point", int'(rd_got), 0);
        chk("R7 read done", t_done, 56);
        run_cmd(3'd2, 1'b0, c, 9999, 1'b1, 1'b1);
        run_cmd(3'd1, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R5 restart sda release", t_sda1, 9);
        chk("R5 restart scl rise", t_scl1, 32);
        chk("R5 restart sda fall", t_sda2, 57);
        chk("R5 restart scl fall", t_scl2, 104);
        run_cmd(3'd2, 1'b1, c, 9999, 1'b1, 1'b1);
        run_cmd(3'd4, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R6 stop sda low", t_sda1, 9);
        chk("R6 stop scl rise", t_scl1, 32);
        chk("R6 stop sda release", t_sda2, 57);
        chk("R8 stop done", t_done, 57);
        chk("R1 idle scl after stop", int'(scl_oe), 0);
        chk("R1 idle sda after stop", int'(sda_oe), 0);
    endtask

    task automatic t_undef_op();
        run_cmd(3'd6, 1'b0, mk_cfg(3, 2, 1, 0, 0), 9999, 1'b1, 1'b1);
        chk("R10 undef done", t_done, 0);
        chk("R10 undef ready", int'(rdy_k0), 1);
        chk("R10 undef scl", t_scl1, -1);
        chk("R10 undef sda", t_sda1, -1);
    endtask

    task automatic t_wide_counts();
        logic [47:0] c;
        c = mk_cfg(1, 4, 15, 3, 2);  // l=2 h=5 s clamps to 7 u=4 p=3
        run_cmd(3'd0, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R4 start u=4 sda", t_sda1, 161);
        chk("R4 start u=4 scl", t_scl1, 360);
        run_cmd(3'd2, 1'b1, c, 9999, 1'b1, 1'b1);
        chk("R3 clamped update point", t_sda1, 15);
        chk("R2 scl rise l=2", t_scl1, 16);
        chk("R2 scl fall h=5", t_scl2, 56);
        run_cmd(3'd4, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R6 stop p=3 release", t_sda2, 137);
    endtask

    task automatic t_standard_mode();
        logic [47:0] c;
        c = mk_cfg(49, 49, 0, 0, 0);
        run_cmd(3'd0, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R4 100k start setup 401", t_sda1, 401);
        chk("R4 100k start scl", t_scl1, 1200);
        run_cmd(3'd2, 1'b1, c, 9999, 1'b1, 1'b1);
        chk("R3 100k update", t_sda1, 51);
        chk("R2 100k low 400", t_scl1, 400);
        chk("R2 100k period 800", t_scl2, 800);
        run_cmd(3'd4, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R6 100k stop", t_sda2, 801);
    endtask

    task automatic t_fast_mode();
        logic [47:0] c;
        c = mk_cfg(15, 8, 1, 0, 0);
        run_cmd(3'd0, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R4 400k start sda", t_sda1, 73);
        chk("R4 400k start scl", t_scl1, 216);
        run_cmd(3'd2, 1'b1, c, 9999, 1'b1, 1'b1);
        chk("R3 400k hold 33", t_sda1, 33);
        chk("R2 400k low 128", t_scl1, 128);
        chk("R2 400k period 200", t_scl2, 200);
        run_cmd(3'd4, 1'b0, c, 9999, 1'b1, 1'b1);
        chk("R6 400k stop", t_sda2, 201);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_small_cfg();
        t_undef_op();
        t_wide_counts();
        t_standard_mode();
        t_fast_mode();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule